// File: doc/BRIEF.md
# Subtract-With-Borrow ALU with Status Flags

This block is the subtract path of an 8-bit accumulator datapath. On a valid strobe it takes a minuend, a subtrahend and an incoming borrow. It registers the difference (minuend minus subtrahend minus borrow, wrapped to the data width) together with three status flags:

- the borrow out of the top bit,
- the borrow out of the low nibble,
- the signed overflow indication, formed from borrow semantics rather than from an adder's carries.

Outputs change only when a valid strobe arrives. Otherwise they hold their last value.

Multi-byte subtraction works by chaining. The caller subtracts the least significant bytes first with the borrow input clear. It then feeds each returned borrow flag into the borrow input of the next byte up.

The data width and the nibble boundary are parameters. A parameter also selects one of two internal borrow structures: a per-bit ripple chain, or wide arithmetic with taps at the nibble and sign boundaries. Both give identical results.

Top module: `sbb_alu`

## Requirements
- R1: One clock edge after `in_vld` is sampled high, `diff` equals `minuend - subtrahend - borrow_in` modulo 2^DATA_W.
- R2: `cy_out` is 1 exactly when the unsigned minuend is smaller than the subtrahend plus `borrow_in`; otherwise it is 0.
- R3: `ac_out` is 1 exactly when the minuend's low NIB_W bits, taken as unsigned, are smaller than the subtrahend's low NIB_W bits plus `borrow_in` (NIB_W = 4 by default).
- R4: `ov_out` is the XOR of the borrow into the top bit and the borrow out of it. In signed terms it is 1 when the true signed difference lies outside the DATA_W-bit two's-complement range.
- R5: `out_vld` is `in_vld` delayed by exactly one clock.
- R6: While `in_vld` is low, `diff`, `cy_out`, `ac_out` and `ov_out` keep their previous values, whatever the operand inputs do.
- R7: While `rst_n` is low (asynchronous, active low), `diff`, all three flags and `out_vld` are 0.
- R8: Minuend C9h, subtrahend 54h and borrow 1 give 74h with CY=0, AC=0 and OV=1. The same operands with borrow 0 give 75h.
- R9: For a two-byte subtraction, feeding `cy_out` of the low byte into `borrow_in` of the high byte yields the correct 16-bit difference, and the high byte's `cy_out` is the 16-bit borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operands are valid this cycle |
| minuend | input | DATA_W | Accumulator value |
| subtrahend | input | DATA_W | Operand subtracted from the accumulator |
| borrow_in | input | 1 | Incoming borrow, subtracted as well |
| out_vld | output | 1 | Registered result updated on the last edge |
| diff | output | DATA_W | Registered difference |
| cy_out | output | 1 | Borrow out of the top bit |
| ac_out | output | 1 | Borrow out of the low nibble |
| ov_out | output | 1 | Signed overflow |

## Verification
The bench builds two instances at DATA_W = 8 and NIB_W = 4, one with the ripple chain (IMPL = 0) and one with the tapped arithmetic form (IMPL = 1). At that width every one of the 131,072 operand and borrow combinations can be streamed through both instances, one per clock. Each result is checked against an unsigned reference for the difference and borrow, a nibble comparison for the auxiliary flag, and a signed-range reference for overflow. Directed cases then cover the hold behaviour, reset in the middle of a run, and a chained two-byte subtraction.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
   // borrow structure variants
   localparam int IMPL_RIPPLE = 0;
   localparam int IMPL_ARITH  = 1;

   typedef struct packed {
      logic cy;
      logic ac;
      logic ov;
   } sbb_flags_t;
endpackage

// File: rtl/sbb_ripple_core.sv
module sbb_ripple_core #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              bin,
   output logic [DATA_W-1:0] dout,
   output sbb_pkg::sbb_flags_t flg
);
   logic [DATA_W:0] brw;

   assign brw[0] = bin;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign dout[i]  = op_a[i] ^ op_b[i] ^ brw[i];
      assign brw[i+1] = (~op_a[i] & op_b[i]) | (~(op_a[i] ^ op_b[i]) & brw[i]);
   end

   assign flg.cy = brw[DATA_W];
   assign flg.ac = brw[NIB_W];
   assign flg.ov = brw[DATA_W] ^ brw[DATA_W-1];
endmodule

// File: rtl/sbb_arith_core.sv
module sbb_arith_core #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              bin,
   output logic [DATA_W-1:0] dout,
   output sbb_pkg::sbb_flags_t flg
);
   localparam int LOW_W = DATA_W - 1;

   logic [DATA_W:0] full_d;
   logic [NIB_W:0]  nib_d;
   logic [LOW_W:0]  low_d;

   assign full_d = {1'b0, op_a} - {1'b0, op_b} - {{DATA_W{1'b0}}, bin};
   assign nib_d  = {1'b0, op_a[NIB_W-1:0]} - {1'b0, op_b[NIB_W-1:0]}
                 - {{NIB_W{1'b0}}, bin};
   assign low_d  = {1'b0, op_a[LOW_W-1:0]} - {1'b0, op_b[LOW_W-1:0]}
                 - {{LOW_W{1'b0}}, bin};

   assign dout   = full_d[DATA_W-1:0];
   assign flg.cy = full_d[DATA_W];
   assign flg.ac = nib_d[NIB_W];
   assign flg.ov = full_d[DATA_W] ^ low_d[LOW_W];
endmodule

// File: rtl/sbb_out_stage.sv
module sbb_out_stage #(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [DATA_W-1:0]   d_in,
   input  sbb_pkg::sbb_flags_t f_in,
   output logic                vld_q,
   output logic [DATA_W-1:0]   d_q,
   output sbb_pkg::sbb_flags_t f_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         d_q   <= '0;
         f_q   <= '0;
      end else begin
         vld_q <= load;
         if (load) begin
            d_q <= d_in;
            f_q <= f_in;
         end
      end
   end
endmodule

// File: rtl/sbb_alu.sv
module sbb_alu #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4,
   parameter int IMPL   = sbb_pkg::IMPL_RIPPLE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] minuend,
   input  logic [DATA_W-1:0] subtrahend,
   input  logic              borrow_in,
   output logic              out_vld,
   output logic [DATA_W-1:0] diff,
   output logic              cy_out,
   output logic              ac_out,
   output logic              ov_out
);
   import sbb_pkg::*;

   if (DATA_W < 2) begin : g_bad_w
      $error("sbb_alu: DATA_W must be at least 2");
   end
   if (NIB_W < 1 || NIB_W >= DATA_W) begin : g_bad_nib
      $error("sbb_alu: NIB_W must lie in 1..DATA_W-1");
   end
   if (IMPL != IMPL_RIPPLE && IMPL != IMPL_ARITH) begin : g_bad_impl
      $error("sbb_alu: unknown IMPL");
   end

   logic [DATA_W-1:0] d_comb;
   sbb_flags_t        f_comb;
   sbb_flags_t        f_reg;

   if (IMPL == IMPL_ARITH) begin : g_arith
      sbb_arith_core #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_core (
         .op_a (minuend),
         .op_b (subtrahend),
         .bin  (borrow_in),
         .dout (d_comb),
         .flg  (f_comb)
      );
   end else begin : g_ripple
      sbb_ripple_core #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_core (
         .op_a (minuend),
         .op_b (subtrahend),
         .bin  (borrow_in),
         .dout (d_comb),
         .flg  (f_comb)
      );
   end

   sbb_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (in_vld),
      .d_in  (d_comb),
      .f_in  (f_comb),
      .vld_q (out_vld),
      .d_q   (diff),
      .f_q   (f_reg)
   );

   assign cy_out = f_reg.cy;
   assign ac_out = f_reg.ac;
   assign ov_out = f_reg.ov;
endmodule

// File: rtl/sbb_alu_chk.sv
module sbb_alu_chk #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic [DATA_W-1:0] minuend,
   input logic [DATA_W-1:0] subtrahend,
   input logic              borrow_in,
   input logic              out_vld,
   input logic [DATA_W-1:0] diff,
   input logic              cy_out,
   input logic              ac_out,
   input logic              ov_out
);
   logic [DATA_W:0] ref_w;
   logic            ref_ov;

   assign ref_w  = {1'b0, minuend} - {1'b0, subtrahend} - {{DATA_W{1'b0}}, borrow_in};
   assign ref_ov = (minuend[DATA_W-1] != subtrahend[DATA_W-1])
                && (ref_w[DATA_W-1] != minuend[DATA_W-1]);

   AST_DIFF_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> diff == $past(ref_w[DATA_W-1:0])); // R1
   AST_BORROW_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> cy_out == $past({1'b0, minuend} < ({1'b0, subtrahend} + {{DATA_W{1'b0}}, borrow_in}))); // R2
   AST_NIB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> ac_out == $past({1'b0, minuend[NIB_W-1:0]} < ({1'b0, subtrahend[NIB_W-1:0]} + {{NIB_W{1'b0}}, borrow_in}))); // R3
   AST_SIGNED_OV: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> ov_out == $past(ref_ov)); // R4
   AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld); // R5
   AST_VLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld); // R5
   AST_HOLD_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(diff)); // R6
   AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable({cy_out, ac_out, ov_out})); // R6

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (diff == '0 && !cy_out && !ac_out && !ov_out && !out_vld); // R7
      end
   end
endmodule

bind sbb_alu sbb_alu_chk #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_vld     (in_vld),
   .minuend    (minuend),
   .subtrahend (subtrahend),
   .borrow_in  (borrow_in),
   .out_vld    (out_vld),
   .diff       (diff),
   .cy_out     (cy_out),
   .ac_out     (ac_out),
   .ov_out     (ov_out)
);

// File: tb/sbb_alu_bench.sv
`timescale 1ns/1ps
module sbb_alu_bench;
   localparam int DW = 8;
   localparam int NW = 4;
   localparam int NVEC = 10;
   localparam int WATCH_CYC = 180000;

   // {a, b, bin, exp_diff, exp_cy, exp_ac, exp_ov}
   localparam logic [27:0] VEC [NVEC] = '{
      {8'hC9, 8'h54, 1'b1, 8'h74, 1'b0, 1'b0, 1'b1},
      {8'hC9, 8'h54, 1'b0, 8'h75, 1'b0, 1'b0, 1'b1},
      {8'h00, 8'h01, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0},
      {8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0},
      {8'h80, 8'h01, 1'b0, 8'h7F, 1'b0, 1'b1, 1'b1},
      {8'h7F, 8'hFF, 1'b0, 8'h80, 1'b1, 1'b0, 1'b1},
      {8'h10, 8'h01, 1'b0, 8'h0F, 1'b0, 1'b1, 1'b0},
      {8'h55, 8'h55, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0},
      {8'hFF, 8'hFF, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0},
      {8'h34, 8'h12, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_vld = 1'b0;
   logic [DW-1:0] a = '0, b = '0;
   logic          bin = 1'b0;
   logic          vld0, vld1, cy0, cy1, ac0, ac1, ov0, ov1;
   logic [DW-1:0] d0, d1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   sbb_alu #(.DATA_W(DW), .NIB_W(NW), .IMPL(0)) u_sbb_alu (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .minuend(a), .subtrahend(b),
      .borrow_in(bin), .out_vld(vld0), .diff(d0), .cy_out(cy0), .ac_out(ac0), .ov_out(ov0));

   sbb_alu #(.DATA_W(DW), .NIB_W(NW), .IMPL(1)) u_sbb_alu_alt (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .minuend(a), .subtrahend(b),
      .borrow_in(bin), .out_vld(vld1), .diff(d1), .cy_out(cy1), .ac_out(ac1), .ov_out(ov1));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [10:0] model(input int ia, input int ib, input int ic);
      int ud, sa, sb, sd;
      logic r_cy, r_ac, r_ov;
      ud   = ia - ib - ic;
      r_cy = (ud < 0);
      r_ac = ((ia % 16) < ((ib % 16) + ic));
      sa   = (ia >= 128) ? ia - 256 : ia;
      sb   = (ib >= 128) ? ib - 256 : ib;
      sd   = sa - sb - ic;
      r_ov = (sd < -128) || (sd > 127);
      return {ud[7:0], r_cy, r_ac, r_ov};
   endfunction

   task automatic drive(input logic [DW-1:0] ia, input logic [DW-1:0] ib, input logic ic);
      @(negedge clk);
      a = ia; b = ib; bin = ic; in_vld = 1'b1;
   endtask

   initial begin : watchdog
      repeat (WATCH_CYC) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [10:0] prev_exp;
      bit          have_prev;
      logic [DW-1:0] lo_d;
      logic          lo_cy;

      // R7: reset state
      repeat (3) @(negedge clk);
      chk("R7 reset diff", d0, 0);
      chk("R7 reset flags", {cy0, ac0, ov0, vld0}, 0);
      rst_n = 1'b1;

      // table of directed vectors (R1 R2 R3 R4 R8)
      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i][27:20], VEC[i][19:12], VEC[i][11]);
         @(negedge clk);
         chk("R1/R8 table diff", d0, VEC[i][10:3]);
         chk("R2 R3 R4 table flags", {cy0, ac0, ov0}, VEC[i][2:0]);
         chk("R5 valid follows strobe", vld0, 1);
         in_vld = 1'b0;
      end

      // R6: hold while strobe low, operands move
      @(negedge clk);
      a = 8'h00; b = 8'hFF; bin = 1'b1;
      @(negedge clk);
      a = 8'h3C; b = 8'h11;
      @(negedge clk);
      chk("R6 hold diff", d0, 8'h22);
      chk("R6 hold flags", {cy0, ac0, ov0}, 3'b000);
      chk("R5 valid low", vld0, 0);

      // R9: chained two-byte subtraction 1234h - 2345h = EEEFh, borrow 1
      drive(8'h34, 8'h45, 1'b0);
      @(negedge clk);
      lo_d = d0; lo_cy = cy0;
      a = 8'h12; b = 8'h23; bin = lo_cy;
      @(negedge clk);
      chk("R9 chained result", {d0, lo_d}, 16'hEEEF);
      chk("R9 chained borrow", cy0, 1);
      in_vld = 1'b0;

      // exhaustive stream, one vector per clock, both variants (R1 R2 R3 R4)
      have_prev = 0;
      prev_exp = '0;
      for (int ia = 0; ia < 256; ia++) begin
         for (int ib = 0; ib < 256; ib++) begin
            for (int ic = 0; ic < 2; ic++) begin
               @(negedge clk);
               if (have_prev) begin
                  chk("R1 R2 R3 R4 sweep ripple", {d0, cy0, ac0, ov0}, prev_exp);
                  chk("R1 R2 R3 R4 sweep arith", {d1, cy1, ac1, ov1}, prev_exp);
               end
               a = ia[7:0]; b = ib[7:0]; bin = ic[0]; in_vld = 1'b1;
               prev_exp = model(ia, ib, ic);
               have_prev = 1;
            end
         end
      end
      @(negedge clk);
      chk("R1 R2 R3 R4 sweep ripple last", {d0, cy0, ac0, ov0}, prev_exp);
      chk("R1 R2 R3 R4 sweep arith last", {d1, cy1, ac1, ov1}, prev_exp);
      in_vld = 1'b0;

      // R7: reset in the middle of a run
      drive(8'h00, 8'h01, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R7 midrun diff", d0, 0);
      chk("R7 midrun flags", {cy0, ac0, ov0, vld0}, 0);
      @(negedge clk);
      chk("R7 reset held with strobe", {d0, cy0, ac0, ov0, vld0}, 0);
      in_vld = 1'b0;

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule